// File: doc/BRIEF.md
# Watchdog and Wakeup Stabilization Timer

This block is an 8-bit timer counter that advances on a prescaled CPU clock and serves two purposes. In normal running it acts as a watchdog. Software must clear the counter before it rolls over out of bit 7. If it does not, the block raises a one-cycle reset request and returns its own counter and control register to their reset values. Writing one particular 4-bit key into the upper half of the control register turns the watchdog off.

The block also measures a wait after stop mode ends. On entry to stop mode the counter is cleared and frozen, and the CPU clock enable drops. A wakeup event restarts the counter. The clock source for this interval depends on how the wakeup is tagged. A wakeup tagged as power-on uses the slowest divider. A wakeup tagged as an interrupt uses the divider that software last programmed. The CPU clock enable returns when the counter carries out of bit 3, which is 16 counter ticks after the restart.

Top module: `wdt_stab_timer`

## Requirements
- R1: The control register uses bits [7:4] as the watchdog key and bits [3:2] as the divider select: 00 selects DIV0 (default 4096), 01 selects DIV1 (1024), 10 selects DIV2 (128) and 11 selects DIV3 (16). Bit 1 is a write-only clear and bit 0 is reserved. Both read back as 0, so reads return {key, select, 2'b00}.
- R2: After rst_ni the control register reads 00h, the counter reads 0, rst_req_o is low and cpu_clk_en_o is high.
- R3: A write with bit 1 set clears the counter to 0 at that clock edge and restarts the prescaler. k cycles after that edge, the live counter output reads floor(k / DIV[select]).
- R4: While the key is not 1010b, the counter stepping from 255 to 0 makes rst_req_o high in the cycle after that edge. At the same edge the counter and the control register return to 0.
- R5: rst_req_o is high for exactly one cycle per overflow.
- R6: With key 1010b, the counter wraps from 255 to 0 and keeps counting, and rst_req_o stays low.
- R7: If a clear write falls on the same edge as a watchdog overflow, the clear wins: the counter goes to 0 and no reset request is made.
- R8: Raising stop_i clears the counter and drops cpu_clk_en_o at the next edge. While stopped, the counter stays at 0 and no reset request is made, whatever the elapsed time.
- R9: A wakeup with wake_por_i low restarts the counter on the programmed divider. cpu_clk_en_o rises, with the counter reading 16, 16*DIV[select] cycles after the wakeup edge. Until then it stays low.
- R10: A wakeup with wake_por_i high times the interval on DIV0, whatever the programmed select. cpu_clk_en_o rises 16*DIV0 cycles after the wakeup edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| cnt_rdata_o | output | 8 | Live counter value |
| stop_i | input | 1 | Stop mode request (level) |
| wake_i | input | 1 | Wakeup event pulse while stopped |
| wake_por_i | input | 1 | Wakeup tag: 1 = power-on, 0 = interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
A software clear and a watchdog overflow can land on the same clock edge. The bench provokes this by programming the fastest divider, waiting until the counter reads 255 with the prescaler one cycle short of a tick, and then issuing a clear write on exactly the overflow edge. The result is judged at the ports. The counter must read 0, rst_req_o must stay low in the following cycle, and the running tally of reset pulses must not change.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STOP = 2'd1,
    MODE_STAB = 2'd2
  } wst_mode_e;

  localparam logic [3:0] WD_OFF_KEY = 4'b1010;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned STAB_BITS = 4;
endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler #(
  parameter int unsigned DIV0 = 4096,
  parameter int unsigned DIV1 = 1024,
  parameter int unsigned DIV2 = 128,
  parameter int unsigned DIV3 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned DIVS [4] = '{DIV0, DIV1, DIV2, DIV3};
  localparam int unsigned MAXD01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned MAXD23 = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned MAXD   = (MAXD01 > MAXD23) ? MAXD01 : MAXD23;
  localparam int unsigned PW     = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [PW-1:0] lim [4];
  logic [PW-1:0] pre_q;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = PW'(DIVS[g] - 1);
  end

  // >= guards against a select change leaving pre_q above the new limit
  assign tick_o = en_i & (pre_q >= lim[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (en_i)   pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  a_r3_presc_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/wst_ctrl_reg.sv
module wst_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       wd_rst_i,
  output logic [3:0] key_o,
  output logic [1:0] sel_o,
  output logic       clr_o,
  output logic [7:0] rdata_o
);
  logic [3:0] key_q;
  logic [1:0] sel_q;

  // watchdog self-reset takes priority over a plain write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      sel_q <= '0;
    end else if (wd_rst_i) begin
      key_q <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      key_q <= wdata_i[7:4];
      sel_q <= wdata_i[3:2];
    end
  end

  assign clr_o   = we_i & wdata_i[1];
  assign key_o   = key_q;
  assign sel_o   = sel_q;
  assign rdata_o = {key_q, sel_q, 2'b00};

  a_r4_ctl_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_i |=> (rdata_o == 8'h00));
endmodule

// File: rtl/wst_mode_fsm.sv
module wst_mode_fsm
  import wst_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stop_i,
  input  logic      wake_i,
  input  logic      wake_por_i,
  input  logic      stab_done_i,
  output wst_mode_e mode_o,
  output logic      por_o,
  output logic      enter_stop_o,
  output logic      wake_go_o
);
  wst_mode_e mode_q, mode_d;
  logic      por_q;

  assign enter_stop_o = (mode_q == MODE_RUN) & stop_i;
  assign wake_go_o    = (mode_q == MODE_STOP) & wake_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (stop_i)      mode_d = MODE_STOP;
      MODE_STOP: if (wake_i)      mode_d = MODE_STAB;
      MODE_STAB: if (stab_done_i) mode_d = MODE_RUN;
      default:                    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      por_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (wake_go_o) por_q <= wake_por_i;
    end
  end

  assign mode_o = mode_q;
  assign por_o  = por_q;

  a_r8_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !wake_i) |=> (mode_q == MODE_STOP));
endmodule

// File: rtl/wdt_stab_timer.sv
module wdt_stab_timer
  import wst_pkg::*;
#(
  parameter int unsigned DIV0 = 4096,
  parameter int unsigned DIV1 = 1024,
  parameter int unsigned DIV2 = 128,
  parameter int unsigned DIV3 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  output logic [7:0] cnt_rdata_o,
  input  logic       stop_i,
  input  logic       wake_i,
  input  logic       wake_por_i,
  output logic       rst_req_o,
  output logic       cpu_clk_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [STAB_BITS-1:0] STAB_LAST = '1;

  wst_mode_e        mode;
  logic             por_wake, enter_stop, wake_go;
  logic [3:0]       key;
  logic [1:0]       ctl_sel, div_sel;
  logic             sw_clr, tick, wd_en, wd_fire, cnt_clr, stab_done;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_req_q;

  wst_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .wd_rst_i (wd_fire),
    .key_o    (key),
    .sel_o    (ctl_sel),
    .clr_o    (sw_clr),
    .rdata_o  (ctl_rdata_o)
  );

  wst_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_i       (stop_i),
    .wake_i       (wake_i),
    .wake_por_i   (wake_por_i),
    .stab_done_i  (stab_done),
    .mode_o       (mode),
    .por_o        (por_wake),
    .enter_stop_o (enter_stop),
    .wake_go_o    (wake_go)
  );

  // power-on wakeup times the interval on the slowest divider
  assign div_sel = (mode == MODE_STAB && por_wake) ? 2'b00 : ctl_sel;

  wst_prescaler #(
    .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode != MODE_STOP),
    .clr_i  (cnt_clr),
    .sel_i  (div_sel),
    .tick_o (tick)
  );

  assign wd_en     = (key != WD_OFF_KEY);
  // software clear and stop entry both beat an overflow on the same edge
  assign wd_fire   = (mode == MODE_RUN) & wd_en & tick & (cnt_q == CNT_MAX)
                   & ~sw_clr & ~enter_stop;
  assign cnt_clr   = sw_clr | enter_stop | wake_go | wd_fire;
  assign stab_done = (mode == MODE_STAB) & tick & (cnt_q[STAB_BITS-1:0] == STAB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wd_fire;
      if (cnt_clr)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_rdata_o  = cnt_q;
  assign rst_req_o    = rst_req_q;
  assign cpu_clk_en_o = (mode == MODE_RUN);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r4_cnt_zero_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cnt_rdata_o == '0));

  a_r3_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr |=> (cnt_q == '0));

  a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr |=> !rst_req_o);

  a_r6_wrap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_RUN && !wd_en && tick && cnt_q == CNT_MAX && !sw_clr && !enter_stop)
    |=> (cnt_q == '0 && !rst_req_o));

  a_r8_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_STOP) |-> (cnt_q == '0 && !rst_req_o && !cpu_clk_en_o));

  a_r9_release_at_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> (cnt_rdata_o == 8'd16));
endmodule

// File: tb/sim_wdt_stab_timer.sv
module sim_wdt_stab_timer;
  localparam int unsigned D0 = 32;
  localparam int unsigned D1 = 16;
  localparam int unsigned D2 = 8;
  localparam int unsigned D3 = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata, cnt_rdata;
  logic       stop = 1'b0, wake = 1'b0, wake_por = 1'b0;
  logic       rst_req, cpu_clk_en;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_stab_timer #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ctl_we_i     (ctl_we),
    .ctl_wdata_i  (ctl_wdata),
    .ctl_rdata_o  (ctl_rdata),
    .cnt_rdata_o  (cnt_rdata),
    .stop_i       (stop),
    .wake_i       (wake),
    .wake_por_i   (wake_por),
    .rst_req_o    (rst_req),
    .cpu_clk_en_o (cpu_clk_en)
  );

  always @(negedge clk) if (rst_ni && rst_req) pulses++;

  // table: write value (with clear), cycles after write edge, expected count
  localparam int NV = 6;
  localparam logic [7:0] V_WD  [NV] = '{8'h02, 8'h06, 8'h0A, 8'h0E, 8'hAE, 8'h03};
  localparam int         V_K   [NV] = '{100, 100, 100, 100, 40, 40};
  localparam int         V_CNT [NV] = '{3, 6, 12, 25, 10, 1};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; one clock edge passes with the write applied
  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    ctl_wdata = 8'h00;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    wait_cyc(3);
    rst_ni = 1'b1;
    // R2 reset state
    check("R2 ctl after reset", ctl_rdata, 8'h00);
    check("R2 cnt after reset", cnt_rdata, 0);
    check("R2 rst_req after reset", rst_req, 0);
    check("R2 clk_en after reset", cpu_clk_en, 1);

    // R1 R3 table walk
    for (int i = 0; i < NV; i++) begin
      wr(V_WD[i]);
      wait_cyc(V_K[i]);
      check("R3 counter rate", cnt_rdata, V_CNT[i]);
      check("R1 readback", ctl_rdata, int'(V_WD[i] & 8'hFC));
    end

    // R4 R5 watchdog overflow on fastest divider
    p0 = pulses;
    wr(8'h0E);
    wait_cyc(1023);
    check("R4 cnt before overflow", cnt_rdata, 255);
    check("R4 no req before overflow", rst_req, 0);
    wait_cyc(1);
    check("R4 req after overflow", rst_req, 1);
    check("R4 cnt self-reset", cnt_rdata, 0);
    check("R4 ctl self-reset", ctl_rdata, 8'h00);
    wait_cyc(1);
    check("R5 req drops", rst_req, 0);
    check("R5 one pulse", pulses - p0, 1);

    // R6 disabled watchdog wraps
    p0 = pulses;
    wr(8'hAE);
    wait_cyc(1024);
    check("R6 wrapped to zero", cnt_rdata, 0);
    check("R6 no req", rst_req, 0);
    wait_cyc(4);
    check("R6 keeps counting", cnt_rdata, 1);
    check("R6 no pulses", pulses - p0, 0);

    // R7 clear on the overflow edge
    p0 = pulses;
    wr(8'h0E);
    wait_cyc(1023);
    check("R7 at 255", cnt_rdata, 255);
    wr(8'h0E);
    check("R7 cleared", cnt_rdata, 0);
    check("R7 no req", rst_req, 0);
    wait_cyc(2);
    check("R7 no pulses", pulses - p0, 0);

    // R8 stop mode
    p0 = pulses;
    wr(8'h0E);
    wait_cyc(50);
    check("R8 pre-stop count", cnt_rdata, 12);
    stop = 1'b1;
    wait_cyc(1);
    check("R8 cnt cleared", cnt_rdata, 0);
    check("R8 clk gated", cpu_clk_en, 0);
    wait_cyc(2000);
    check("R8 cnt held", cnt_rdata, 0);
    check("R8 no pulses", pulses - p0, 0);

    // R9 interrupt wakeup on programmed divider (D3)
    stop = 1'b0;
    wake = 1'b1;
    wake_por = 1'b0;
    wait_cyc(1);
    wake = 1'b0;
    wait_cyc(16 * D3 - 1);
    check("R9 still gated", cpu_clk_en, 0);
    check("R9 cnt at 15", cnt_rdata, 15);
    wait_cyc(1);
    check("R9 clk enabled", cpu_clk_en, 1);
    check("R9 cnt at 16", cnt_rdata, 16);

    // R10 power-on wakeup uses D0
    stop = 1'b1;
    wait_cyc(1);
    stop = 1'b0;
    wake = 1'b1;
    wake_por = 1'b1;
    wait_cyc(1);
    wake = 1'b0;
    wake_por = 1'b0;
    wait_cyc(16 * D0 - 1);
    check("R10 still gated", cpu_clk_en, 0);
    check("R10 cnt at 15", cnt_rdata, 15);
    wait_cyc(1);
    check("R10 clk enabled", cpu_clk_en, 1);
    check("R10 ctl unchanged", ctl_rdata, 8'h0C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule